// File: doc/BRIEF.md
# Divided-Clock Idle Controller

This block manages the low-power idle state of a processor core. When the core issues an idle request, the controller stops the core clock enable and waits for an enabled interrupt. The request carries a 3-bit divisor code. With code 0, the core sits in plain idle: derived peripheral clocks keep running at full rate and an enabled interrupt wakes the core one cycle later. With codes 1 to 4, the core enters divided idle. In divided idle the core clock enable and the derived peripheral enable (serial clock, timer tick, clock-out) both pulse once every 16, 32, 64 or 128 cycles.

In divided idle the wake condition is evaluated only on those divided pulses, so the time to wake is a whole number of divided periods. A free-running prescaler counter starts at zero on reset and produces the pulses. DMA and auto-buffer cycle-steal requests are granted at any time during idle as single-cycle core enables, and the idle state is kept. The wake pulse tells the core to service the interrupt and then resume at the instruction after the idle request.

The controller has four states. RUN is normal operation. IDLE_FULL is plain idle. IDLE_DIV is divided idle. WAKE is the single exit cycle. It has these transitions:
- RUN to IDLE_FULL on a request with code 0 or 5 to 7.
- RUN to IDLE_DIV on a request with code 1 to 4.
- IDLE_FULL to WAKE on any enabled interrupt.
- IDLE_DIV to WAKE on an enabled interrupt seen in a divided-pulse cycle.
- WAKE to RUN, always.

Top module: `idle_clk_ctrl`

## Requirements
- R1: After reset the block is in RUN: core_en=1, periph_en=1, idle_flag=0, wake_pulse=0.
- R2: An idle_req sampled in RUN with div_code 0 enters plain idle on the next cycle: idle_flag=1, core_en=0, periph_en=1.
- R3: Without an enabled interrupt the block stays in idle for any number of cycles.
- R4: In plain idle, an enabled interrupt (irq_pend[i] & irq_en[i]) on a clock edge gives wake_pulse=1, core_en=1, idle_flag=0 in the next cycle.
- R5: wake_pulse is high for exactly one cycle and is followed by RUN. Outside idle, interrupts never raise wake_pulse.
- R6: An interrupt whose irq_en bit is 0 is ignored and causes no wake.
- R7: During idle, core_en is 1 in exactly the cycles in which any steal_req bit is 1, and idle_flag stays 1.
- R8: div_code 1, 2, 3 and 4 select divided idle with n = 16, 32, 64 and 128. In this mode periph_en is a single-cycle pulse every n cycles, and without steals core_en equals periph_en.
- R9: In divided idle the wake condition is tested only in periph_en pulse cycles. wake_pulse follows the first pulse cycle that has an enabled interrupt, so the wait is at most n cycles. For example, an interrupt raised in the cycle after a pulse gives wake_pulse exactly n cycles later.
- R10: div_code 5, 6 and 7 are treated as 0, which selects plain idle.
- R11: idle_req is ignored while the block is not in RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | Request to enter idle, sampled in RUN |
| div_code | input | CODE_W (3) | Divisor code: 0 none, 1..4 divide by 16/32/64/128 |
| irq_pend | input | NUM_IRQ (6) | Pending interrupt lines |
| irq_en | input | NUM_IRQ (6) | Interrupt enable mask, 1 = enabled |
| steal_req | input | NUM_STEAL (3) | DMA / auto-buffer cycle-steal requests |
| core_en | output | 1 | Core clock enable |
| periph_en | output | 1 | Enable for derived peripheral clocks |
| idle_flag | output | 1 | High while in idle |
| wake_pulse | output | 1 | One-cycle pulse on leaving idle |

## Verification
If the state register is wrong, the fault appears at the ports within one cycle. A missed plain-idle wake leaves idle_flag high in the cycle after an enabled interrupt. A wrong divided state shows up as periph_en dropping outside idle, or staying high inside divided idle. If the latched ratio or the prescaler is wrong, the spacing of the periph_en pulses is wrong and the wake arrives n cycles late. A mask or steal error shows as a wake without a cause, or as core_en failing to follow steal_req in the same cycle.

// File: rtl/idle_ctl_pkg.sv
package idle_ctl_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_IDLE_FULL = 2'd1,
        ST_IDLE_DIV  = 2'd2,
        ST_WAKE      = 2'd3
    } idle_state_t;
endpackage

// File: rtl/idle_prescaler.sv
module idle_prescaler #(
    parameter int unsigned BASE_LOG2  = 4,
    parameter int unsigned NUM_RATIOS = 4,
    parameter int unsigned SEL_W      = $clog2(NUM_RATIOS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             tick
);
    localparam int unsigned CNT_W = BASE_LOG2 + NUM_RATIOS - 1;

    logic [CNT_W-1:0]      cnt_q;
    logic [NUM_RATIOS-1:0] tap;

    // Free-running: every ratio divides the wrap length, so all taps stay periodic.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_tap
        assign tap[i] = &cnt_q[BASE_LOG2+i-1:0];
    end

    assign tick = tap[ratio_sel];
endmodule

// File: rtl/idle_event_merge.sv
module idle_event_merge #(
    parameter int unsigned NUM_IRQ   = 6,
    parameter int unsigned NUM_STEAL = 3
) (
    input  logic [NUM_IRQ-1:0]   irq_pend,
    input  logic [NUM_IRQ-1:0]   irq_en,
    input  logic [NUM_STEAL-1:0] steal_req,
    output logic                 wake_any,
    output logic                 steal_any
);
    assign wake_any  = |(irq_pend & irq_en);
    assign steal_any = |steal_req;
endmodule

// File: rtl/idle_fsm.sv
module idle_fsm
    import idle_ctl_pkg::*;
#(
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned NUM_RATIOS = 4,
    parameter int unsigned SEL_W      = $clog2(NUM_RATIOS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_req,
    input  logic [CODE_W-1:0] div_code,
    input  logic              wake_any,
    input  logic              steal_any,
    input  logic              tick,
    output logic [SEL_W-1:0]  ratio_sel,
    output logic              core_en,
    output logic              periph_en,
    output logic              idle_flag,
    output logic              wake_pulse
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(NUM_RATIOS);

    idle_state_t      state_q, state_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             code_div;

    assign code_div = (div_code != '0) && (div_code <= MAX_CODE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_RUN: begin
                if (idle_req) begin
                    if (code_div) begin
                        state_d = ST_IDLE_DIV;
                        sel_d   = SEL_W'(div_code - CODE_W'(1));
                    end else begin
                        state_d = ST_IDLE_FULL;
                    end
                end
            end
            ST_IDLE_FULL: if (wake_any)         state_d = ST_WAKE;
            ST_IDLE_DIV:  if (tick && wake_any) state_d = ST_WAKE;
            ST_WAKE:                            state_d = ST_RUN;
            default:                            state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs
    always_comb begin
        core_en    = 1'b1;
        periph_en  = 1'b1;
        idle_flag  = 1'b0;
        wake_pulse = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_IDLE_FULL: begin
                core_en   = steal_any;
                idle_flag = 1'b1;
            end
            ST_IDLE_DIV: begin
                core_en   = tick | steal_any;
                periph_en = tick;
                idle_flag = 1'b1;
            end
            ST_WAKE:  wake_pulse = 1'b1;
            default: ;
        endcase
    end

    assign ratio_sel = sel_q;
endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl #(
    parameter int unsigned NUM_IRQ    = 6,
    parameter int unsigned NUM_STEAL  = 3,
    parameter int unsigned BASE_LOG2  = 4,
    parameter int unsigned NUM_RATIOS = 4,
    parameter int unsigned CODE_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 idle_req,
    input  logic [CODE_W-1:0]    div_code,
    input  logic [NUM_IRQ-1:0]   irq_pend,
    input  logic [NUM_IRQ-1:0]   irq_en,
    input  logic [NUM_STEAL-1:0] steal_req,
    output logic                 core_en,
    output logic                 periph_en,
    output logic                 idle_flag,
    output logic                 wake_pulse
);
    localparam int unsigned SEL_W = $clog2(NUM_RATIOS);

    logic             wake_any;
    logic             steal_any;
    logic             tick;
    logic [SEL_W-1:0] ratio_sel;

    idle_event_merge #(
        .NUM_IRQ   (NUM_IRQ),
        .NUM_STEAL (NUM_STEAL)
    ) merge_i (
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .steal_req (steal_req),
        .wake_any  (wake_any),
        .steal_any (steal_any)
    );

    idle_prescaler #(
        .BASE_LOG2  (BASE_LOG2),
        .NUM_RATIOS (NUM_RATIOS),
        .SEL_W      (SEL_W)
    ) presc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .tick      (tick)
    );

    idle_fsm #(
        .CODE_W     (CODE_W),
        .NUM_RATIOS (NUM_RATIOS),
        .SEL_W      (SEL_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_req   (idle_req),
        .div_code   (div_code),
        .wake_any   (wake_any),
        .steal_any  (steal_any),
        .tick       (tick),
        .ratio_sel  (ratio_sel),
        .core_en    (core_en),
        .periph_en  (periph_en),
        .idle_flag  (idle_flag),
        .wake_pulse (wake_pulse)
    );
endmodule

// File: rtl/idle_clk_ctrl_chk.sv
module idle_clk_ctrl_chk #(
    parameter int unsigned NUM_IRQ   = 6,
    parameter int unsigned NUM_STEAL = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_IRQ-1:0]   irq_pend,
    input logic [NUM_IRQ-1:0]   irq_en,
    input logic [NUM_STEAL-1:0] steal_req,
    input logic                 core_en,
    input logic                 periph_en,
    input logic                 idle_flag,
    input logic                 wake_pulse
);
    assert_wake_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    assert_run_no_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_flag && !wake_pulse) |=> !wake_pulse);

    assert_wake_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (core_en && periph_en && !idle_flag));

    assert_wake_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(|(irq_pend & irq_en)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !(|(irq_pend & irq_en))) |=> idle_flag);

    assert_steal_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && (|steal_req)) |-> core_en);

    assert_wake_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(periph_en));

    assert_periph_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |-> idle_flag);
endmodule

bind idle_clk_ctrl idle_clk_ctrl_chk #(
    .NUM_IRQ   (NUM_IRQ),
    .NUM_STEAL (NUM_STEAL)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_pend   (irq_pend),
    .irq_en     (irq_en),
    .steal_req  (steal_req),
    .core_en    (core_en),
    .periph_en  (periph_en),
    .idle_flag  (idle_flag),
    .wake_pulse (wake_pulse)
);

// File: tb/idle_clk_ctrl_tb_top.sv
`timescale 1ns/100ps
module idle_clk_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_req = 1'b0;
    logic [2:0] div_code = 3'd0;
    logic [5:0] irq_pend = '0;
    logic [5:0] irq_en = '0;
    logic [2:0] steal_req = '0;
    logic       core_en, periph_en, idle_flag, wake_pulse;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    idle_clk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .div_code(div_code),
        .irq_pend(irq_pend), .irq_en(irq_en), .steal_req(steal_req),
        .core_en(core_en), .periph_en(periph_en), .idle_flag(idle_flag),
        .wake_pulse(wake_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic enter_idle(input logic [2:0] code);
        idle_req = 1'b1; div_code = code;
        step();
        idle_req = 1'b0; div_code = 3'd0;
    endtask

    task automatic t_reset();
        chk(core_en && periph_en && !idle_flag && !wake_pulse, "R1", "reset outputs",
            {core_en, periph_en, idle_flag, wake_pulse}, 4'b1100);
    endtask

    task automatic t_plain_idle();
        bit held = 1'b1;
        enter_idle(3'd0);
        chk(idle_flag && !core_en && periph_en, "R2", "plain idle outputs",
            {core_en, periph_en, idle_flag}, 3'b011);
        for (int i = 0; i < 40; i++) begin
            step();
            if (!idle_flag || wake_pulse || !periph_en) held = 1'b0;
        end
        chk(held, "R3", "idle held without interrupt", held, 1);
        irq_pend = 6'b000100; irq_en = 6'b000100;
        step();
        chk(wake_pulse && core_en && !idle_flag, "R4", "one-cycle wake",
            {wake_pulse, core_en, idle_flag}, 3'b110);
        step();
        chk(!wake_pulse && core_en && periph_en && !idle_flag, "R5", "back to run",
            {wake_pulse, core_en, periph_en, idle_flag}, 4'b0110);
        held = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            if (wake_pulse || idle_flag) held = 1'b0;
        end
        chk(held, "R5", "no wake pulse in run with irq", held, 1);
        irq_pend = '0; irq_en = '0;
        step();
    endtask

    task automatic t_masked();
        bit held = 1'b1;
        enter_idle(3'd0);
        irq_pend = 6'b111011; irq_en = 6'b000100;
        for (int i = 0; i < 30; i++) begin
            step();
            if (!idle_flag || wake_pulse) held = 1'b0;
        end
        chk(held, "R6", "masked irq ignored in plain idle", held, 1);
        irq_pend = 6'b000100;
        step();
        chk(wake_pulse, "R4", "wake after unmask", wake_pulse, 1);
        irq_pend = '0; irq_en = '0;
        step();
    endtask

    task automatic t_steal();
        enter_idle(3'd0);
        step();
        steal_req = 3'b010; #0.5;
        chk(core_en && idle_flag, "R7", "steal grants core_en in idle",
            {core_en, idle_flag}, 2'b11);
        step();
        steal_req = 3'b000; #0.5;
        chk(!core_en && idle_flag, "R7", "core_en drops after steal",
            {core_en, idle_flag}, 2'b01);
        irq_pend = 6'b000001; irq_en = 6'b000001;
        step();
        irq_pend = '0; irq_en = '0;
        step();
    endtask

    task automatic t_div(input logic [2:0] code, input int n);
        int  cnt;
        int  lat;
        bit  prev_p;
        bit  ok;
        enter_idle(code);
        chk(idle_flag, "R8", $sformatf("divided idle entered code %0d", code), idle_flag, 1);
        // masked interrupts over two divided periods
        irq_pend = 6'b100000; irq_en = 6'b011111;
        ok = 1'b1;
        for (int i = 0; i < 2 * n; i++) begin
            step();
            if (!idle_flag || wake_pulse) ok = 1'b0;
        end
        chk(ok, "R6", $sformatf("masked irq ignored in divided idle n=%0d", n), ok, 1);
        irq_pend = '0; irq_en = '0;
        cnt = 0;
        while (!periph_en && cnt < 2 * n) begin step(); cnt++; end
        ok = 1'b1;
        for (int k = 0; k < 3; k++) begin
            cnt = 0;
            do begin
                step(); cnt++;
                if (core_en != periph_en) ok = 1'b0;
            end while (!periph_en && cnt < 4 * n);
            chk(cnt == n, "R8", $sformatf("pulse spacing code %0d", code), cnt, n);
        end
        chk(ok, "R8", "core_en follows periph_en", ok, 1);
        step();
        steal_req = 3'b001; #0.5;
        chk(core_en && !periph_en && idle_flag, "R7", "steal in divided idle",
            {core_en, periph_en, idle_flag}, 3'b101);
        steal_req = '0; #0.5;
        irq_pend = 6'b010000; irq_en = 6'b010000;
        lat = 0; prev_p = 1'b0;
        do begin
            prev_p = periph_en;
            step(); lat++;
        end while (!wake_pulse && lat < 4 * n);
        chk(lat == n, "R9", $sformatf("quantised wake latency n=%0d", n), lat, n);
        chk(prev_p && wake_pulse && !idle_flag, "R9", "wake follows divided pulse",
            {prev_p, wake_pulse, idle_flag}, 3'b110);
        irq_pend = '0; irq_en = '0;
        step();
        chk(periph_en && core_en && !idle_flag, "R5", "run after divided wake",
            {periph_en, core_en, idle_flag}, 3'b110);
    endtask

    task automatic t_bad_code(input logic [2:0] code);
        bit ok = 1'b1;
        enter_idle(code);
        for (int i = 0; i < 20; i++) begin
            if (!periph_en || core_en || !idle_flag) ok = 1'b0;
            step();
        end
        chk(ok, "R10", $sformatf("code %0d acts as plain idle", code), ok, 1);
        irq_pend = 6'b000010; irq_en = 6'b000010;
        step();
        chk(wake_pulse, "R10", "one-cycle wake for reserved code", wake_pulse, 1);
        irq_pend = '0; irq_en = '0;
        step();
    endtask

    task automatic t_req_in_idle();
        bit ok = 1'b1;
        enter_idle(3'd0);
        idle_req = 1'b1; div_code = 3'd2;
        step();
        idle_req = 1'b0; div_code = 3'd0;
        for (int i = 0; i < 40; i++) begin
            if (!periph_en || !idle_flag) ok = 1'b0;
            step();
        end
        chk(ok, "R11", "idle_req ignored while idle", ok, 1);
        irq_pend = 6'b001000; irq_en = 6'b001000;
        step();
        chk(wake_pulse, "R11", "plain wake kept after ignored request", wake_pulse, 1);
        irq_pend = '0; irq_en = '0;
        step();
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_plain_idle();
        t_masked();
        t_steal();
        t_div(3'd1, 16);
        t_div(3'd2, 32);
        t_div(3'd3, 64);
        t_div(3'd4, 128);
        t_bad_code(3'd5);
        t_bad_code(3'd7);
        t_req_in_idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule